// File: doc/BRIEF.md
# Serial GF(2^233) Field Multiplier

This block multiplies two elements of the binary extension field GF(2^233) and returns their product reduced modulo x^233 + x^74 + 1. It does not build a 233x233 array. A single 64x64 carry-less partial multiplier is used once per cycle for nine cycles. Each operand is zero-extended to 256 bits and split into four 64-bit words. A two-level, two-way Karatsuba split selects the nine word pairs. At each level the split takes the low halves, the high halves, and the XOR of the two halves. Every 127-bit partial product is shifted into place and XOR-ed into a wide accumulator. After the ninth step the accumulator is folded down to 233 bits.

A host pulses `start` while `busy` is low and holds the operands for that one cycle. It then waits for the one-cycle `done` pulse, after which `product` holds the result. The partial multiplier sits behind a fixed port set. The `PM_IMPL` parameter picks a schoolbook or a one-level Karatsuba version, and the logic around it stays the same.

Top module: `gf233_serial_mul`

## Requirements
- R1: `product` equals the carry-less product of the two operands captured at the accepted start, reduced modulo x^233 + x^74 + 1.
- R2: Operands are sampled only at the accepted start edge. Later changes on `opA`/`opB` do not alter the result.
- R3: `done` is high in the cycle that starts exactly 10 rising edges after the edge that accepted `start`. `busy` is high over those cycles and low while `done` is high.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: A `start` seen while `busy` is high is ignored. The running result is unchanged, and no extra `done` or `busy` period follows.
- R6: `product` holds its value from one `done` until the next completion, whatever the inputs do.
- R7: While reset is low, `busy`, `done` and `product` are all zero.
- R8: The operand values zero, one and all-ones give correct products (zero times anything is zero, and one times a is a).
- R9: Both partial multiplier variants (`PM_IMPL` 0 and 1) give identical products and identical timing.
- R10: A new `start` is accepted in the same cycle that `done` is high, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when not busy |
| opA | input | 233 | First field operand |
| opB | input | 233 | Second field operand |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 233 | Reduced field product |

## Verification
A wrong step counter or a wrong operand selector makes one of the nine partial products land at the wrong word offset. This corrupts `product` at the very first `done`, usually in many bits, so a comparison against a bit-serial reference catches it on the first operation. A fault in the reduction shows up only when the raw product has bits at position 233 or above, so the corner values and random operands are mixed on purpose. Faults in the state sequence show up as a latency other than ten cycles, a `done` wider than one cycle, or an extra `done` after an ignored start, and each of these is visible within one operation.

// File: rtl/gf233_pkg.sv
package gf233_pkg;
  // number of partial products in a two-level two-way Karatsuba split
  localparam int KaraSteps = 9;
  // one capture cycle folds into the nine steps, plus one reduction cycle
  localparam int LatencyCycles = KaraSteps + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_RED
  } mulState_t;

  typedef struct packed {
    logic       load;
    logic       accum;
    logic       finish;
    logic [1:0] outerSel;
    logic [1:0] innerSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gf233_pmul.sv
module gf233_pmul #(
  parameter int WORD_W = 64,
  parameter int IMPL   = 0
) (
  input  logic [WORD_W-1:0]   a,
  input  logic [WORD_W-1:0]   b,
  output logic [2*WORD_W-2:0] p
);
  localparam int PROD_W = 2 * WORD_W - 1;
  localparam int SUB_W  = WORD_W / 2;
  localparam int SUBP_W = 2 * SUB_W - 1;

  generate
    if (IMPL == 0) begin : g_school
      always_comb begin
        p = '0;
        for (int i = 0; i < WORD_W; i++) begin
          if (b[i]) p = p ^ (PROD_W'(a) << i);
        end
      end
    end else begin : g_kara
      function automatic logic [SUBP_W-1:0] subMul(input logic [SUB_W-1:0] x,
                                                   input logic [SUB_W-1:0] y);
        logic [SUBP_W-1:0] r;
        r = '0;
        for (int i = 0; i < SUB_W; i++) begin
          if (y[i]) r = r ^ (SUBP_W'(x) << i);
        end
        return r;
      endfunction

      logic [SUBP_W-1:0] pLo, pHi, pMid;
      always_comb begin
        pLo  = subMul(a[SUB_W-1:0], b[SUB_W-1:0]);
        pHi  = subMul(a[WORD_W-1:SUB_W], b[WORD_W-1:SUB_W]);
        pMid = subMul(a[SUB_W-1:0] ^ a[WORD_W-1:SUB_W],
                      b[SUB_W-1:0] ^ b[WORD_W-1:SUB_W]);
        p = PROD_W'(pLo)
          ^ (PROD_W'(pLo ^ pHi ^ pMid) << SUB_W)
          ^ (PROD_W'(pHi) << WORD_W);
      end
    end
  endgenerate
endmodule

// File: rtl/gf233_ctrl.sv
module gf233_ctrl
  import gf233_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t ctrl,
  output logic        busy,
  output logic        done
);
  mulState_t  state;
  logic [1:0] outerCnt, innerCnt;
  logic       lastStep;

  assign lastStep = (outerCnt == 2'd2) && (innerCnt == 2'd2);

  always_comb begin
    ctrl.load     = (state == ST_IDLE) && start;
    ctrl.accum    = (state == ST_MUL);
    ctrl.finish   = (state == ST_RED);
    ctrl.outerSel = outerCnt;
    ctrl.innerSel = innerCnt;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      outerCnt <= '0;
      innerCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_RED);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_MUL;
            outerCnt <= '0;
            innerCnt <= '0;
          end
        end
        ST_MUL: begin
          if (lastStep) begin
            state <= ST_RED;
          end else if (innerCnt == 2'd2) begin
            innerCnt <= '0;
            outerCnt <= outerCnt + 2'd1;
          end else begin
            innerCnt <= innerCnt + 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf233_datapath.sv
module gf233_datapath
  import gf233_pkg::*;
#(
  parameter int FIELD_W  = 233,
  parameter int WORD_W   = 64,
  parameter int POLY_MID = 74,
  parameter int PM_IMPL  = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctrl,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  output logic [FIELD_W-1:0] product
);
  localparam int HALF_W = 2 * WORD_W;
  localparam int PAD_W  = 4 * WORD_W;
  localparam int PROD_W = 2 * WORD_W - 1;
  localparam int ACC_W  = 2 * PAD_W;

  logic [PAD_W-1:0]  aReg, bReg;
  logic [ACC_W-1:0]  acc;
  logic [HALF_W-1:0] halfA, halfB;
  logic [WORD_W-1:0] wordA, wordB;
  logic [PROD_W-1:0] pmOut;
  logic [ACC_W-1:0]  innerTerm, contrib;

  function automatic logic [HALF_W-1:0] pickHalf(input logic [PAD_W-1:0] v,
                                                 input logic [1:0] sel);
    case (sel)
      2'd0:    return v[HALF_W-1:0];
      2'd1:    return v[PAD_W-1:HALF_W];
      default: return v[HALF_W-1:0] ^ v[PAD_W-1:HALF_W];
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pickWord(input logic [HALF_W-1:0] v,
                                                 input logic [1:0] sel);
    case (sel)
      2'd0:    return v[WORD_W-1:0];
      2'd1:    return v[HALF_W-1:WORD_W];
      default: return v[WORD_W-1:0] ^ v[HALF_W-1:WORD_W];
    endcase
  endfunction

  // Karatsuba recombination: low -> (1+x^s), high -> (x^s + x^2s), mid -> x^s
  function automatic logic [ACC_W-1:0] place(input logic [ACC_W-1:0] t,
                                             input logic [1:0] sel,
                                             input int shift);
    case (sel)
      2'd0:    return t ^ (t << shift);
      2'd1:    return (t << shift) ^ (t << (2 * shift));
      default: return t << shift;
    endcase
  endfunction

  // fold every bit at or above FIELD_W using x^FIELD_W = x^POLY_MID + 1
  function automatic logic [FIELD_W-1:0] fold(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] t;
    t = v;
    for (int i = ACC_W - 1; i >= FIELD_W; i--) begin
      if (t[i]) begin
        t[i]                      = 1'b0;
        t[i-FIELD_W]              = ~t[i-FIELD_W];
        t[i-FIELD_W+POLY_MID]     = ~t[i-FIELD_W+POLY_MID];
      end
    end
    return t[FIELD_W-1:0];
  endfunction

  always_comb begin
    halfA     = pickHalf(aReg, ctrl.outerSel);
    halfB     = pickHalf(bReg, ctrl.outerSel);
    wordA     = pickWord(halfA, ctrl.innerSel);
    wordB     = pickWord(halfB, ctrl.innerSel);
    innerTerm = place(ACC_W'(pmOut), ctrl.innerSel, WORD_W);
    contrib   = place(innerTerm, ctrl.outerSel, HALF_W);
  end

  gf233_pmul #(
    .WORD_W(WORD_W),
    .IMPL  (PM_IMPL)
  ) u_pmul (
    .a(wordA),
    .b(wordB),
    .p(pmOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      acc     <= '0;
      product <= '0;
    end else begin
      if (ctrl.load) begin
        aReg <= PAD_W'(opA);
        bReg <= PAD_W'(opB);
        acc  <= '0;
      end else if (ctrl.accum) begin
        acc <= acc ^ contrib;
      end
      if (ctrl.finish) product <= fold(acc);
    end
  end
endmodule

// File: rtl/gf233_serial_mul.sv
module gf233_serial_mul
  import gf233_pkg::*;
#(
  parameter int FIELD_W  = 233,
  parameter int WORD_W   = 64,
  parameter int POLY_MID = 74,
  parameter int PM_IMPL  = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  output logic               busy,
  output logic               done,
  output logic [FIELD_W-1:0] product
);
  ctrlStrobe_t ctrl;

  gf233_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  gf233_datapath #(
    .FIELD_W (FIELD_W),
    .WORD_W  (WORD_W),
    .POLY_MID(POLY_MID),
    .PM_IMPL (PM_IMPL)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );
endmodule

// File: rtl/gf233_serial_mul_chk.sv
module gf233_serial_mul_chk
  import gf233_pkg::*;
#(
  parameter int FIELD_W = 233
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [FIELD_W-1:0] product
);
  logic [4:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 5'd1;
    else           runLen <= '0;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runLen == 5'(LatencyCycles)));

  assert_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && runLen < 5'(LatencyCycles - 1)) |=> busy);

  assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(product) |-> done);
endmodule

bind gf233_serial_mul gf233_serial_mul_chk #(.FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/test_gf233_serial_mul.sv
`timescale 1ns/1ps
module test_gf233_serial_mul;
  localparam int FW = 233;
  localparam int TAP = 74;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] opA = '0, opB = '0;
  logic          busy, done, busyAlt, doneAlt;
  logic [FW-1:0] product, productAlt;

  int nChecks = 0, nFail = 0, cyc = 0;
  bit finished = 0;
  logic [FW-1:0] expQ[$];
  int            cycQ[$];
  string         tagQ[$];
  logic [FW-1:0] lastExp = '0;
  bit            prevDone = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gf233_serial_mul #(.PM_IMPL(0)) i_gf233_serial_mul (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .product(product));

  gf233_serial_mul #(.PM_IMPL(1)) i_gf233_serial_mul_alt (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .busy(busyAlt), .done(doneAlt), .product(productAlt));

  function automatic logic [FW-1:0] refMul(input logic [FW-1:0] a, input logic [FW-1:0] b);
    logic [FW-1:0] r;
    logic top;
    r = '0;
    for (int i = FW - 1; i >= 0; i--) begin
      top = r[FW-1];
      r = r << 1;
      if (top) begin
        r[0]   = ~r[0];
        r[TAP] = ~r[TAP];
      end
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] randElem();
    logic [255:0] w;
    for (int k = 0; k < 8; k++) w[k*32 +: 32] = $urandom;
    return w[FW-1:0];
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  // driver: waits for idle, pulses start, scrambles operands afterwards (R2)
  task automatic issue(input logic [FW-1:0] a, input logic [FW-1:0] b, input string tag);
    bit waited = 0;
    @(negedge clk);
    while (busy) begin
      waited = 1;
      @(negedge clk);
    end
    if (waited) check(done == 1'b1, "R10", FW'(done), FW'(1));
    start = 1'b1;
    opA = a;
    opB = b;
    expQ.push_back(refMul(a, b));
    cycQ.push_back(cyc);
    tagQ.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    opA = randElem();
    opB = randElem();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) check(1'b0, "R4", FW'(1), FW'(0));
      if (done != doneAlt) check(1'b0, "R9", FW'(doneAlt), FW'(done));
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5", FW'(1), FW'(0));
        end else begin
          logic [FW-1:0] e;
          int c;
          string t;
          e = expQ.pop_front();
          c = cycQ.pop_front();
          t = tagQ.pop_front();
          lastExp = e;
          check(product == e, t, product, e);
          check(productAlt == e, "R9", productAlt, e);
          check(cyc - c == 11, "R3", FW'(cyc - c), FW'(11));
          check(!busy, "R3", FW'(busy), FW'(0));
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [FW-1:0] ones, one, x;
    ones = '1;
    one  = FW'(1);
    repeat (3) @(negedge clk);
    // R7: reset state
    check(busy == 1'b0, "R7", FW'(busy), FW'(0));
    check(done == 1'b0, "R7", FW'(done), FW'(0));
    check(product == '0, "R7", product, '0);
    rstN = 1'b1;

    // R8 corner operands
    x = randElem();
    issue('0, x, "R8");
    issue(x, '0, "R8");
    issue(one, x, "R8");
    issue(x, one, "R8");
    issue(one, one, "R8");
    issue(ones, ones, "R8");
    issue(ones, one, "R8");
    // R1: single high bits force reduction
    issue(one << (FW - 1), one << (FW - 1), "R1");
    issue(one << (FW - 1), one << 200, "R1");

    // R5: start while busy ignored, then no stray done (R5) and product hold (R6)
    issue(randElem(), randElem(), "R1");
    repeat (3) @(negedge clk);
    start = 1'b1;
    opA = randElem();
    opB = randElem();
    check(busy == 1'b1, "R5", FW'(busy), FW'(1));
    @(negedge clk);
    start = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      opA = randElem();
      check(!done && !busy, "R5", FW'({done, busy}), FW'(0));
      check(product == lastExp, "R6", product, lastExp);
    end

    // R2: random operands, scrambled after capture, back to back (R10)
    for (int n = 0; n < 24; n++) issue(randElem(), randElem(), "R2");

    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule